// File: doc/BRIEF.md
# Edge-Triggered Interrupt Controller

This block gathers interrupt requests from eleven sources and presents a single prioritised request, its vector index and its priority level to a CPU core. Three of the sources are external vectors. Thirteen external input pins feed them, and each pin has its own edge setting: off, rising, falling or both edges. The other eight sources are on-chip peripherals: three timers, ADC, PWM, UART, a serial interface and a base timer. Each of them delivers a single-cycle pulse or a held level.

Every source latches into a pending flag. Software clears a flag by writing a one to it. Software also sets a per-source enable, a per-source priority bit and a global enable through a small register port. The controller keeps a two-entry record of the handlers in service, one entry per priority level. This record lets a high-level request preempt a low-level handler, while a low-level request cannot preempt a high-level one. The CPU pulses an acknowledge when it takes the presented request and pulses a return when a handler ends. Two wake outputs serve the low-power modes. In idle, any enabled pending source wakes the core. In stop, only the external vectors and the base timer do.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every register reads 0, and irq_req_o, idle_wake_o and stop_wake_o are 0.
- R2: Pins 0-4 feed source 0, pins 5-8 feed source 1 and pins 9-12 feed source 2. After a pin changes ahead of a clock edge, the pending flag of its vector is visible after the third rising clock edge and not after the second.
- R3: The two-bit mode of pin p selects its trigger: 00 off, 01 rising, 10 falling, 11 both edges. An edge that the mode does not select leaves the pending flag unchanged.
- R4: Bit k of periph_req_i sets the pending flag of source 3+k on the next clock edge. The sources are 3 timer0, 4 timer1, 5 timer2, 6 ADC, 7 PWM, 8 UART, 9 serial interface and 10 base timer.
- R5: Writing to address 4 clears each pending flag whose data bit is 1. A set event in the same cycle wins over the clear.
- R6: irq_req_o is 0 while the global enable (address 0 bit 15) is 0. Pending flags keep latching during this time.
- R7: Among eligible requests, a high-level source (priority bit 1) wins over a low-level one. Within one level the lowest source index wins. irq_vec_o carries the index and irq_high_o carries the level.
- R8: A source whose enable bit (address 0 bits 10:0) is 0 never drives irq_req_o, but its flag still sets.
- R9: While a low-level handler is in service only high-level requests are presented. While a high-level handler is in service no request is presented.
- R10: irq_ack_i while irq_req_o is 1 marks the presented level as in service. irq_reti_i ends the high-level handler if one is in service, and otherwise ends the low-level handler.
- R11: idle_wake_o is 1 whenever any enabled source is pending, regardless of the global enable and of the handlers in service.
- R12: stop_wake_o is 1 only when source 0, 1, 2 or 10 is both enabled and pending.
- R13: The register map is: address 0 holds the enables and the global enable; address 1 holds the priority bits 10:0; address 2 holds the modes of pins 0-7, with pin p at bits 2p+1:2p; address 3 holds the modes of pins 8-12 at bits 9:0; address 4 holds the pending flags. All other addresses and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 13 | External interrupt pins, asynchronous |
| periph_req_i | input | 8 | Peripheral request pulses or levels, sources 3-10 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on reg_addr_i |
| irq_ack_i | input | 1 | CPU takes the presented request |
| irq_reti_i | input | 1 | CPU returns from a handler |
| irq_req_o | output | 1 | Request to the CPU |
| irq_vec_o | output | 4 | Index of the presented source |
| irq_high_o | output | 1 | Level of the presented source |
| idle_wake_o | output | 1 | Wake from idle mode |
| stop_wake_o | output | 1 | Wake from stop mode |

## Verification
The bench times the pin path to the exact edge. A synchroniser that is one stage short, or edge detection that is too deep, shows up as a flag that appears one cycle early or late. It also drives the edge that the mode does not select, on a rising-only pin and on a disabled pin, and it checks that a pulse arriving in the same cycle as its own clear is kept rather than lost. A directed nesting sequence covers a low-level handler blocking a low request, a high request preempting it, and a return that pops the wrong level and would present or hide the wrong vector. Random peripheral traffic with random enables, priorities and clears exposes any arbitration order other than high first and then lowest index, and any stop wake raised by a source outside the allowed four.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC    = 11;
  localparam int N_EXT    = 3;
  localparam int N_PERIPH = N_SRC - N_EXT;
  localparam int N_PIN    = 13;
  localparam int VEC_W    = $clog2(N_SRC);
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int MODE_W   = 2 * N_PIN;
  localparam int MODE_HI_W = MODE_W - DATA_W;
  localparam int BTM_SRC  = 10;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef enum logic [ADDR_W-1:0] {
    A_EN      = 3'd0,
    A_PRIO    = 3'd1,
    A_MODE_LO = 3'd2,
    A_MODE_HI = 3'd3,
    A_PEND    = 3'd4
  } reg_addr_e;

  // pin groups onto external vectors
  function automatic int pin_to_vec(input int p);
    if (p < 5) return 0;
    else if (p < 9) return 1;
    else return 2;
  endfunction

  function automatic logic [N_SRC-1:0] stop_mask();
    logic [N_SRC-1:0] m;
    m = '0;
    for (int i = 0; i < N_EXT; i++) m[i] = 1'b1;
    m[BTM_SRC] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge
  import irq_pkg::*;
#(
  parameter int PINS = N_PIN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PINS-1:0]   pin_i,
  input  logic [2*PINS-1:0] mode_i,
  output logic [PINS-1:0]   hit_o
);
  logic [PINS-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic rise, fall;
    assign rise     = sync_q[p] & ~prev_q[p];
    assign fall     = ~sync_q[p] & prev_q[p];
    assign hit_o[p] = (rise & mode_i[2*p]) | (fall & mode_i[2*p+1]);
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  set_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              gie_o,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  prio_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [N_SRC-1:0]  pend_o
);
  localparam int EN_PAD = DATA_W - 1 - N_SRC;
  localparam int PR_PAD = DATA_W - N_SRC;
  localparam int MH_PAD = DATA_W - MODE_HI_W;

  logic              gie_q;
  logic [N_SRC-1:0]  en_q, prio_q, pend_q, clr;
  logic [MODE_W-1:0] mode_q;

  assign clr = (we_i && addr_i == A_PEND) ? wdata_i[N_SRC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      prio_q <= '0;
      mode_q <= '0;
      pend_q <= '0;
    end else begin
      if (we_i) begin
        case (addr_i)
          A_EN: begin
            en_q  <= wdata_i[N_SRC-1:0];
            gie_q <= wdata_i[DATA_W-1];
          end
          A_PRIO:    prio_q <= wdata_i[N_SRC-1:0];
          A_MODE_LO: mode_q[DATA_W-1:0] <= wdata_i;
          A_MODE_HI: mode_q[MODE_W-1:DATA_W] <= wdata_i[MODE_HI_W-1:0];
          default: ;
        endcase
      end
      // set wins over clear
      pend_q <= (pend_q & ~clr) | set_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_EN:      rdata_o = {gie_q, {EN_PAD{1'b0}}, en_q};
      A_PRIO:    rdata_o = {{PR_PAD{1'b0}}, prio_q};
      A_MODE_LO: rdata_o = mode_q[DATA_W-1:0];
      A_MODE_HI: rdata_o = {{MH_PAD{1'b0}}, mode_q[MODE_W-1:DATA_W]};
      A_PEND:    rdata_o = {{PR_PAD{1'b0}}, pend_q};
      default:   rdata_o = '0;
    endcase
  end

  assign gie_o  = gie_q;
  assign en_o   = en_q;
  assign prio_o = prio_q;
  assign mode_o = mode_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             gie_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             high_o,
  output logic             isr_lo_o,
  output logic             isr_hi_o
);
  logic             isr_lo_q, isr_hi_q, lo_n, hi_n;
  logic [N_SRC-1:0] elig, cand_hi, cand_lo;
  logic [VEC_W-1:0] idx_hi, idx_lo;
  logic             allow_hi, allow_lo;

  assign elig     = pend_i & en_i;
  assign allow_hi = gie_i & ~isr_hi_q;
  assign allow_lo = allow_hi & ~isr_lo_q;
  assign cand_hi  = elig & prio_i;
  assign cand_lo  = elig & ~prio_i;

  // lowest index wins: scan downwards
  always_comb begin
    idx_hi = '0;
    idx_lo = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand_hi[i]) idx_hi = VEC_W'(i);
      if (cand_lo[i]) idx_lo = VEC_W'(i);
    end
  end

  always_comb begin
    req_o  = 1'b0;
    high_o = 1'b0;
    vec_o  = '0;
    if (allow_hi && |cand_hi) begin
      req_o  = 1'b1;
      high_o = 1'b1;
      vec_o  = idx_hi;
    end else if (allow_lo && |cand_lo) begin
      req_o = 1'b1;
      vec_o = idx_lo;
    end
  end

  always_comb begin
    hi_n = isr_hi_q;
    lo_n = isr_lo_q;
    if (reti_i) begin
      if (isr_hi_q) hi_n = 1'b0;
      else          lo_n = 1'b0;
    end
    if (ack_i && req_o) begin
      if (high_o) hi_n = 1'b1;
      else        lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_lo_q <= 1'b0;
      isr_hi_q <= 1'b0;
    end else begin
      isr_lo_q <= lo_n;
      isr_hi_q <= hi_n;
    end
  end

  assign isr_lo_o = isr_lo_q;
  assign isr_hi_o = isr_hi_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PIN-1:0]    ext_pin_i,
  input  logic [N_PERIPH-1:0] periph_req_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                irq_ack_i,
  input  logic                irq_reti_i,
  output logic                irq_req_o,
  output logic [VEC_W-1:0]    irq_vec_o,
  output logic                irq_high_o,
  output logic                idle_wake_o,
  output logic                stop_wake_o
);
  localparam logic [N_SRC-1:0] STOP_MASK = stop_mask();

  logic [N_PIN-1:0]  pin_hit;
  logic [N_EXT-1:0]  ext_set;
  logic [N_SRC-1:0]  src_set, en_w, prio_w, pend_w;
  logic [MODE_W-1:0] mode_w;
  logic              gie_w, isr_lo_w, isr_hi_w;

  irq_pin_edge #(.PINS(N_PIN)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .mode_i (mode_w),
    .hit_o  (pin_hit)
  );

  always_comb begin
    ext_set = '0;
    for (int v = 0; v < N_EXT; v++)
      for (int p = 0; p < N_PIN; p++)
        if (pin_to_vec(p) == v) ext_set[v] = ext_set[v] | pin_hit[p];
  end

  assign src_set = {periph_req_i, ext_set};

  irq_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .set_i   (src_set),
    .rdata_o (reg_rdata_o),
    .gie_o   (gie_w),
    .en_o    (en_w),
    .prio_o  (prio_w),
    .mode_o  (mode_w),
    .pend_o  (pend_w)
  );

  irq_arbiter u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend_w),
    .en_i     (en_w),
    .prio_i   (prio_w),
    .gie_i    (gie_w),
    .ack_i    (irq_ack_i),
    .reti_i   (irq_reti_i),
    .req_o    (irq_req_o),
    .vec_o    (irq_vec_o),
    .high_o   (irq_high_o),
    .isr_lo_o (isr_lo_w),
    .isr_hi_o (isr_hi_w)
  );

  assign idle_wake_o = |(pend_w & en_w);
  assign stop_wake_o = |(pend_w & en_w & STOP_MASK);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req,
  input logic [VEC_W-1:0] vec,
  input logic             high,
  input logic             gie,
  input logic             isr_lo,
  input logic             isr_hi,
  input logic             ack,
  input logic             reti,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] en,
  input logic             idle_wake,
  input logic             stop_wake
);
  p_req_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |-> (vec < VEC_W'(N_SRC)) && pend[vec] && en[vec]);

  p_gie_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie |-> !req);

  p_high_masks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_hi |-> !req);

  p_low_nests_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_lo && req) |-> high);

  p_push_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && high && ack && !reti) |=> isr_hi);

  p_pop_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_hi && reti && !ack) |=> !isr_hi && ($past(isr_lo) == isr_lo));

  p_stop_sub_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_wake |-> idle_wake);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req       (irq_req_o),
  .vec       (irq_vec_o),
  .high      (irq_high_o),
  .gie       (gie_w),
  .isr_lo    (isr_lo_w),
  .isr_hi    (isr_hi_w),
  .ack       (irq_ack_i),
  .reti      (irq_reti_i),
  .pend      (pend_w),
  .en        (en_w),
  .idle_wake (idle_wake_o),
  .stop_wake (stop_wake_o)
);

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [12:0] pin = '0;
  logic [7:0]  preq = '0;
  logic        we = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        req, high, iwake, swake;
  logic [3:0]  vec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ext_pin_i(pin), .periph_req_i(preq),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_ack_i(ack), .irq_reti_i(reti), .irq_req_o(req), .irq_vec_o(vec),
    .irq_high_o(high), .idle_wake_o(iwake), .stop_wake_o(swake)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected {req, high, vec}
  function automatic logic [5:0] exp_sel(input logic [10:0] pd, input logic [10:0] en,
      input logic [10:0] pr, input logic gie, input logic lo, input logic hi);
    logic [10:0] e;
    e = pd & en;
    if (!gie || hi) return 6'd0;
    for (int i = 0; i < 11; i++) if (e[i] && pr[i]) return {2'b11, 4'(i)};
    if (lo) return 6'd0;
    for (int i = 0; i < 11; i++) if (e[i] && !pr[i]) return {2'b10, 4'(i)};
    return 6'd0;
  endfunction

  task automatic chk_sel(input string r, input logic [5:0] e);
    chk(r, {req, high, vec}, e);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [10:0] m_en, m_pr, m_pd, clr;
    logic        m_gie;
    void'($urandom(32'h1d5e));
    cyc(3); rst_ni = 1; cyc(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), d); chk("R1 reg", d, 0); end
    chk("R1 req", req, 0); chk("R1 idle", iwake, 0); chk("R1 stop", swake, 0);

    // R13 map readback
    wr(0, 16'hffff); rd(0, d); chk("R13 en", d, 16'h87ff);
    wr(1, 16'hffff); rd(1, d); chk("R13 prio", d, 16'h07ff);
    wr(3, 16'hffff); rd(3, d); chk("R13 mode hi", d, 16'h03ff);
    wr(5, 16'hffff); rd(5, d); chk("R13 unused", d, 0);
    wr(0, 0); wr(1, 0); wr(3, 0);

    // R2 latency and mapping: pin 6 rising -> src1
    wr(2, 16'h1000);
    @(negedge clk); pin[6] = 1;
    cyc(2); rd(4, d); chk("R2 not yet", d, 0);
    cyc(1); rd(4, d); chk("R2 src1 set", d, 16'h0002);
    wr(4, 16'h7ff);
    // R3 falling edge ignored on rising-only pin
    @(negedge clk); pin[6] = 0; cyc(5); rd(4, d); chk("R3 fall ignored", d, 0);
    // R3 dual edge on pin 12 -> src2
    wr(3, 16'h0300);
    @(negedge clk); pin[12] = 1; cyc(4); rd(4, d); chk("R3 both rise", d, 16'h0004);
    wr(4, 16'h7ff);
    @(negedge clk); pin[12] = 0; cyc(4); rd(4, d); chk("R3 both fall", d, 16'h0004);
    wr(4, 16'h7ff);
    // R3 mode off on pin 0; R2 pin 0 falling -> src0
    @(negedge clk); pin[0] = 1; cyc(4); rd(4, d); chk("R3 off pin", d, 0);
    wr(2, 16'h0002);
    @(negedge clk); pin[0] = 0; cyc(4); rd(4, d); chk("R2 src0 set", d, 16'h0001);
    wr(4, 16'h7ff); wr(2, 0); wr(3, 0);

    // R4 pulse sets next cycle, R8 disabled no req
    @(negedge clk); preq = 8'h01; @(negedge clk); preq = 0;
    rd(4, d); chk("R4 timer0 src3", d, 16'h0008);
    chk("R8 disabled no req", req, 0); chk("R8 no idle", iwake, 0);
    // R5 set wins over clear
    @(negedge clk); preq = 8'h01; we = 1; addr = 4; wdata = 16'h0008;
    @(negedge clk); preq = 0; we = 0;
    rd(4, d); chk("R5 set wins", d, 16'h0008);
    wr(4, 16'h0008); rd(4, d); chk("R5 w1c", d, 0);

    // R6 gie off latches but no request; R11/R12 wakes
    wr(0, 16'h07ff);
    @(negedge clk); preq = 8'h02; @(negedge clk); preq = 0;
    chk("R6 gie off", req, 0); chk("R11 idle", iwake, 1); chk("R12 no stop", swake, 0);
    rd(4, d); chk("R6 latched", d, 16'h0010);
    @(negedge clk); preq = 8'h80; @(negedge clk); preq = 0;
    chk("R12 btm stop", swake, 1);
    wr(4, 16'h7ff);

    // R7/R9/R10 nesting: src3 low, src4 high, src5 low
    wr(1, 16'h0010); wr(0, 16'h8038);
    @(negedge clk); preq = 8'h01; @(negedge clk); preq = 0;
    chk_sel("R7 low vec3", {2'b10, 4'd3});
    ack = 1; @(negedge clk); ack = 0;
    chk_sel("R10 still presented? no, low blocks low R9", 6'd0);
    @(negedge clk); preq = 8'h04; @(negedge clk); preq = 0;
    chk_sel("R9 low blocked", 6'd0);
    chk("R11 idle in service", iwake, 1);
    @(negedge clk); preq = 8'h02; @(negedge clk); preq = 0;
    chk_sel("R9 high preempts", {2'b11, 4'd4});
    ack = 1; @(negedge clk); ack = 0;
    chk_sel("R9 high blocks all", 6'd0);
    reti = 1; @(negedge clk); reti = 0;
    chk_sel("R10 pop high", {2'b11, 4'd4});
    wr(4, 16'h0010);
    chk_sel("R10 low still in service", 6'd0);
    reti = 1; @(negedge clk); reti = 0;
    chk_sel("R10 pop low R7 lowest", {2'b10, 4'd3});

    // random peripheral traffic, empty service record
    wr(0, 0); wr(1, 0); wr(4, 16'h7ff);
    m_en = 0; m_pr = 0; m_pd = 0; m_gie = 0;
    for (int it = 0; it < 400; it++) begin
      if (($urandom & 7) == 0) begin
        d = 16'($urandom); wr(0, d); m_en = d[10:0]; m_gie = d[15];
      end
      if (($urandom & 7) == 0) begin
        d = 16'($urandom); wr(1, d); m_pr = d[10:0];
      end
      @(negedge clk);
      preq = 8'($urandom & $urandom & $urandom);
      clr = 11'($urandom & $urandom);
      we = (($urandom & 3) == 0); addr = 4; wdata = {5'd0, clr};
      if (!we) clr = 0;
      @(negedge clk);
      m_pd = (m_pd & ~clr) | {preq, 3'b000};
      preq = 0; we = 0;
      chk_sel("R7 random arb", exp_sel(m_pd, m_en, m_pr, m_gie, 1'b0, 1'b0));
      chk("R11 random idle", iwake, |(m_pd & m_en));
      chk("R12 random stop", swake, |(m_pd & m_en & 11'h407));
      rd(4, d); chk("R5 random pend", d, {5'd0, m_pd});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule